// File: doc/BRIEF.md
# Ethernet Transmit Jabber and Receive Watchdog Guard

This block sits beside a MAC and stops traffic that runs too long. On the transmit side it watches each frame. In byte mode it counts the transmitted byte strobes. In time mode it counts prescaled millisecond ticks while the frame is active. When the chosen limit is reached it raises `tx_cutoff`. The cut-off is released in one of two ways. In the immediate mode it drops as soon as the transmitter goes idle. Otherwise it is held until the transmitter has stayed idle for a long delay measured in milliseconds.

On the receive side the block counts byte strobes while carrier is present. A reception that is too long raises `rx_block`. The block is lifted only after carrier has stayed low for a short or a long number of bit-time ticks, chosen by a control bit.

Each side also keeps a sticky status flag for its frame. The MAC copies `tx_jab_flag` into the transmit status word and `rx_wd_flag` into the receive status of the frame that tripped. Every limit is a parameter. The defaults place the byte limits at 2304, which is inside the required 2048 to 2560 pass/trip window. The time cut-off defaults to 30 ms, the long hold to 390 ms, and the quiet intervals to 20 and 44 bit times.

Top module: `eth_guard`

## Requirements
- R1: A synchronous active-high reset clears `tx_cutoff`, `rx_block`, `tx_jab_flag` and `rx_wd_flag`. The control input `ctrl` is decoded as follows: bit 0 disables the transmit jabber, bit 1 selects immediate release, bit 2 selects time mode, bit 3 disables the receive watchdog, and bit 4 selects the long quiet interval.
- R2: With `ctrl[2]`=0, a frame starts on the first cycle in which `tx_active` is high; byte strobes in that start cycle are not counted. In the cycle after the TX_CUT_BYTES-th counted `tx_byte` strobe of the frame, both `tx_cutoff` and `tx_jab_flag` are 1. A frame with fewer strobes never trips.
- R3: With `ctrl[2]`=1, `tx_cutoff` rises once `tx_active` has been high for TIME_CUT_MS millisecond ticks. Each tick is TICKS_PER_MS clocks, counted from the cycle after the start cycle.
- R4: While `ctrl[0]`=1, no new transmit cut-off is raised in either mode.
- R5: With `ctrl[1]`=1, a cut-off is released in the cycle after the first cycle in which `tx_active` is low.
- R6: With `ctrl[1]`=0, a cut-off is held until `tx_active` has been low for UNJAB_MS × TICKS_PER_MS consecutive clocks. Any cycle with `tx_active` high restarts this wait.
- R7: `tx_jab_flag` stays 1 after the release and is cleared at the start of the next frame.
- R8: Unless `ctrl[3]`=1, in the cycle after the RX_TRIP_BYTES-th `rx_byte` strobe counted while `rx_crs` is high (counting from the carrier rise, whose own strobe is not counted), both `rx_block` and `rx_wd_flag` are 1.
- R9: `rx_block` is lifted after carrier has been low for QUIET_SHORT (`ctrl[4]`=0) or QUIET_LONG (`ctrl[4]`=1) `bit_tick` pulses. A cycle with `rx_crs` high restarts the count.
- R10: `rx_wd_flag` stays 1 while blocked and after the release. It is cleared by the next carrier rise.
- R11: The transmit and receive guards are independent. Events on both sides in the same cycle are each handled as if alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 5 | Control register bits (see R1) |
| tx_active | input | 1 | Transmit frame in progress |
| tx_byte | input | 1 | One transmitted byte |
| rx_crs | input | 1 | Receive carrier sense |
| rx_byte | input | 1 | One received byte |
| bit_tick | input | 1 | One pulse per bit time |
| tx_cutoff | output | 1 | Transmitter must stop |
| rx_block | output | 1 | Receive path blocked |
| tx_jab_flag | output | 1 | Sticky transmit jabber status |
| rx_wd_flag | output | 1 | Sticky receive watchdog status |

## Verification
The transmit cut-off and the receive trip can land in the same clock. A receive release can also coincide with a transmit release or trip. The bench lines up a transmit frame and a receive frame so that both limits fall due on one edge, and it checks that both outputs rise together. A long random phase then drives both sides at once with changing control bits. A behavioural model of each side is compared against all four outputs on every clock, so any cross-coupling between the two sides shows up as a mismatch.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef struct packed {
    logic rx_long_quiet;
    logic rxwd_off;
    logic time_mode;
    logic unjab_now;
    logic jab_off;
  } guard_ctrl_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/guard_tick_div.sv
module guard_tick_div #(
  parameter int unsigned DIV = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = en & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/guard_tx_jabber.sv
module guard_tx_jabber
  import guard_pkg::*;
#(
  parameter int unsigned TX_CUT_BYTES = 2304,
  parameter int unsigned TICKS_PER_MS = 25000,
  parameter int unsigned TIME_CUT_MS  = 30,
  parameter int unsigned UNJAB_MS     = 390
) (
  input  logic        clk,
  input  logic        rst,
  input  guard_ctrl_t ctrl,
  input  logic        tx_active,
  input  logic        tx_byte,
  output logic        cutoff,
  output logic        flag
);
  localparam int unsigned BW     = $clog2(TX_CUT_BYTES + 1);
  localparam int unsigned MS_MAX = max2(TIME_CUT_MS, UNJAB_MS);
  localparam int unsigned MW     = $clog2(MS_MAX + 1);

  logic          prev_q, cut_q, flag_q;
  logic [BW-1:0] bcnt;
  logic [MW-1:0] mcnt;
  logic          start, counting, ms_tick, pre_clr, pre_en;
  logic          trip_bytes, trip_time, trip, hold_run, release_now;

  assign start      = tx_active & ~prev_q;
  assign counting   = ~cut_q & ~start & tx_active;
  assign trip_bytes = counting & ~ctrl.time_mode & tx_byte &
                      (bcnt == BW'(TX_CUT_BYTES - 1)) & ~ctrl.jab_off;
  assign trip_time  = counting & ctrl.time_mode & ms_tick &
                      (mcnt == MW'(TIME_CUT_MS - 1)) & ~ctrl.jab_off;
  assign trip       = trip_bytes | trip_time;
  assign hold_run   = cut_q & ~tx_active & ~ctrl.unjab_now;
  assign pre_en     = (counting & ctrl.time_mode) | hold_run;
  assign pre_clr    = (~cut_q & start) | trip | (cut_q & tx_active);
  assign release_now = cut_q & ~tx_active &
                       (ctrl.unjab_now | (ms_tick & (mcnt == MW'(UNJAB_MS - 1))));

  guard_tick_div #(.DIV(TICKS_PER_MS)) u_ms_div (
    .clk (clk),
    .rst (rst),
    .clr (pre_clr),
    .en  (pre_en),
    .tick(ms_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cut_q  <= 1'b0;
      flag_q <= 1'b0;
      bcnt   <= '0;
      mcnt   <= '0;
    end else begin
      prev_q <= tx_active;
      if (!cut_q) begin
        if (start) begin
          bcnt   <= '0;
          mcnt   <= '0;
          flag_q <= 1'b0;
        end else if (tx_active) begin
          if (!ctrl.time_mode && tx_byte && bcnt != BW'(TX_CUT_BYTES))
            bcnt <= bcnt + 1'b1;
          if (ctrl.time_mode && ms_tick && mcnt != MW'(MS_MAX))
            mcnt <= mcnt + 1'b1;
        end
        if (trip) begin
          cut_q  <= 1'b1;
          flag_q <= 1'b1;
          mcnt   <= '0;
        end
      end else begin
        if (tx_active) mcnt <= '0;
        else if (release_now) cut_q <= 1'b0;
        else if (ms_tick && mcnt != MW'(MS_MAX)) mcnt <= mcnt + 1'b1;
      end
    end
  end

  assign cutoff = cut_q;
  assign flag   = flag_q;
endmodule

// File: rtl/guard_rx_watchdog.sv
module guard_rx_watchdog
  import guard_pkg::*;
#(
  parameter int unsigned RX_TRIP_BYTES = 2304,
  parameter int unsigned QUIET_SHORT   = 20,
  parameter int unsigned QUIET_LONG    = 44
) (
  input  logic        clk,
  input  logic        rst,
  input  guard_ctrl_t ctrl,
  input  logic        rx_crs,
  input  logic        rx_byte,
  input  logic        bit_tick,
  output logic        block,
  output logic        flag
);
  localparam int unsigned BW   = $clog2(RX_TRIP_BYTES + 1);
  localparam int unsigned QMAX = max2(QUIET_SHORT, QUIET_LONG);
  localparam int unsigned QW   = $clog2(QMAX + 1);

  logic          prev_q, blk_q, flag_q;
  logic [BW-1:0] bcnt;
  logic [QW-1:0] qcnt, qlast;
  logic          start, trip, release_now;

  assign start       = rx_crs & ~prev_q;
  assign qlast       = ctrl.rx_long_quiet ? QW'(QUIET_LONG - 1) : QW'(QUIET_SHORT - 1);
  assign trip        = ~blk_q & ~start & rx_crs & rx_byte &
                       (bcnt == BW'(RX_TRIP_BYTES - 1)) & ~ctrl.rxwd_off;
  assign release_now = blk_q & ~rx_crs & bit_tick & (qcnt == qlast);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      blk_q  <= 1'b0;
      flag_q <= 1'b0;
      bcnt   <= '0;
      qcnt   <= '0;
    end else begin
      prev_q <= rx_crs;
      if (!blk_q) begin
        if (start) begin
          bcnt   <= '0;
          flag_q <= 1'b0;
        end else if (rx_crs && rx_byte && bcnt != BW'(RX_TRIP_BYTES)) begin
          bcnt <= bcnt + 1'b1;
        end
        if (trip) begin
          blk_q  <= 1'b1;
          flag_q <= 1'b1;
          qcnt   <= '0;
        end
      end else begin
        if (rx_crs) qcnt <= '0;
        else if (release_now) blk_q <= 1'b0;
        else if (bit_tick && qcnt != QW'(QMAX)) qcnt <= qcnt + 1'b1;
      end
    end
  end

  assign block = blk_q;
  assign flag  = flag_q;
endmodule

// File: rtl/eth_guard.sv
module eth_guard
  import guard_pkg::*;
#(
  parameter int unsigned TX_CUT_BYTES  = 2304,
  parameter int unsigned RX_TRIP_BYTES = 2304,
  parameter int unsigned TICKS_PER_MS  = 25000,
  parameter int unsigned TIME_CUT_MS   = 30,
  parameter int unsigned UNJAB_MS      = 390,
  parameter int unsigned QUIET_SHORT   = 20,
  parameter int unsigned QUIET_LONG    = 44
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] ctrl,
  input  logic       tx_active,
  input  logic       tx_byte,
  input  logic       rx_crs,
  input  logic       rx_byte,
  input  logic       bit_tick,
  output logic       tx_cutoff,
  output logic       rx_block,
  output logic       tx_jab_flag,
  output logic       rx_wd_flag
);
  guard_ctrl_t cfg;
  assign cfg = guard_ctrl_t'(ctrl);

  guard_tx_jabber #(
    .TX_CUT_BYTES(TX_CUT_BYTES),
    .TICKS_PER_MS(TICKS_PER_MS),
    .TIME_CUT_MS (TIME_CUT_MS),
    .UNJAB_MS    (UNJAB_MS)
  ) u_tx (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (cfg),
    .tx_active(tx_active),
    .tx_byte  (tx_byte),
    .cutoff   (tx_cutoff),
    .flag     (tx_jab_flag)
  );

  guard_rx_watchdog #(
    .RX_TRIP_BYTES(RX_TRIP_BYTES),
    .QUIET_SHORT  (QUIET_SHORT),
    .QUIET_LONG   (QUIET_LONG)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (cfg),
    .rx_crs  (rx_crs),
    .rx_byte (rx_byte),
    .bit_tick(bit_tick),
    .block   (rx_block),
    .flag    (rx_wd_flag)
  );
endmodule

// File: rtl/eth_guard_chk.sv
module eth_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] ctrl,
  input logic       tx_active,
  input logic       rx_crs,
  input logic       rx_byte,
  input logic       bit_tick,
  input logic       tx_cutoff,
  input logic       rx_block,
  input logic       tx_jab_flag,
  input logic       rx_wd_flag
);
  // R2: a new cut-off always comes with the sticky flag
  a_r2_flag_with_cut: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_cutoff) |-> tx_jab_flag);

  // R4: the disable bit blocks any new cut-off
  a_r4_disabled_no_cut: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_cutoff) |-> !$past(ctrl[0]));

  // R5: immediate release once the transmitter is idle
  a_r5_unjab_release: assert property (@(posedge clk) disable iff (rst)
    (tx_cutoff && !tx_active && ctrl[1]) |=> !tx_cutoff);

  // R6: a release only happens from an idle transmitter
  a_r6_release_when_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_cutoff) |-> !$past(tx_active));

  // R8: a receive trip needs a counted byte and sets the flag
  a_r8_trip_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_block) |-> (rx_wd_flag && !$past(ctrl[3]) && $past(rx_byte) && $past(rx_crs)));

  // R9: the block lifts only on a bit tick with carrier low
  a_r9_quiet_release: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_block) |-> (!$past(rx_crs) && $past(bit_tick)));

  // R10: the flag is held for as long as the path is blocked
  a_r10_flag_while_blocked: assert property (@(posedge clk) disable iff (rst)
    rx_block |-> rx_wd_flag);
endmodule

bind eth_guard eth_guard_chk u_eth_guard_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl       (ctrl),
  .tx_active  (tx_active),
  .rx_crs     (rx_crs),
  .rx_byte    (rx_byte),
  .bit_tick   (bit_tick),
  .tx_cutoff  (tx_cutoff),
  .rx_block   (rx_block),
  .tx_jab_flag(tx_jab_flag),
  .rx_wd_flag (rx_wd_flag)
);

// File: tb/test_eth_guard.sv
module test_eth_guard;
  localparam int TXC = 20;
  localparam int RXT = 24;
  localparam int TPM = 4;
  localparam int TC  = 3;
  localparam int UJ  = 4;
  localparam int QS  = 3;
  localparam int QL  = 7;
  localparam int MSMAX = (TC > UJ) ? TC : UJ;
  localparam int QMAX  = (QS > QL) ? QS : QL;

  logic clk = 1'b0;
  logic rst;
  logic [4:0] ctrl;
  logic tx_active, tx_byte, rx_crs, rx_byte, bit_tick;
  logic tx_cutoff, rx_block, tx_jab_flag, rx_wd_flag;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  eth_guard #(
    .TX_CUT_BYTES(TXC), .RX_TRIP_BYTES(RXT), .TICKS_PER_MS(TPM),
    .TIME_CUT_MS(TC), .UNJAB_MS(UJ), .QUIET_SHORT(QS), .QUIET_LONG(QL)
  ) i_eth_guard (
    .clk(clk), .rst(rst), .ctrl(ctrl), .tx_active(tx_active), .tx_byte(tx_byte),
    .rx_crs(rx_crs), .rx_byte(rx_byte), .bit_tick(bit_tick),
    .tx_cutoff(tx_cutoff), .rx_block(rx_block),
    .tx_jab_flag(tx_jab_flag), .rx_wd_flag(rx_wd_flag)
  );

  // behavioural reference model
  bit m_cut, m_tflag, m_tprev, m_blk, m_rflag, m_rprev;
  int m_bcnt, m_ms, m_pre, m_rb, m_q;

  always @(posedge clk) begin
    if (rst) begin
      m_cut = 0; m_tflag = 0; m_tprev = 0; m_bcnt = 0; m_ms = 0; m_pre = 0;
      m_blk = 0; m_rflag = 0; m_rprev = 0; m_rb = 0; m_q = 0;
    end else begin
      bit st, tk;
      st = tx_active && !m_tprev;
      if (!m_cut) begin
        if (st) begin
          m_bcnt = 0; m_ms = 0; m_pre = 0; m_tflag = 0;
        end else if (tx_active) begin
          if (ctrl[2]) begin
            tk = (m_pre == TPM - 1);
            m_pre = tk ? 0 : m_pre + 1;
            if (tk) begin
              if (m_ms == TC - 1 && !ctrl[0]) begin
                m_cut = 1; m_tflag = 1; m_ms = 0; m_pre = 0;
              end else if (m_ms < MSMAX) m_ms++;
            end
          end else if (tx_byte) begin
            if (m_bcnt == TXC - 1 && !ctrl[0]) begin
              m_cut = 1; m_tflag = 1; m_ms = 0; m_pre = 0;
            end
            if (m_bcnt < TXC) m_bcnt++;
          end
        end
      end else begin
        if (tx_active) begin
          m_ms = 0; m_pre = 0;
        end else if (ctrl[1]) begin
          m_cut = 0;
        end else begin
          tk = (m_pre == TPM - 1);
          m_pre = tk ? 0 : m_pre + 1;
          if (tk) begin
            if (m_ms == UJ - 1) m_cut = 0;
            else if (m_ms < MSMAX) m_ms++;
          end
        end
      end
      m_tprev = tx_active;

      st = rx_crs && !m_rprev;
      if (!m_blk) begin
        if (st) begin
          m_rb = 0; m_rflag = 0;
        end else if (rx_crs && rx_byte) begin
          if (m_rb == RXT - 1 && !ctrl[3]) begin
            m_blk = 1; m_rflag = 1; m_q = 0;
          end
          if (m_rb < RXT) m_rb++;
        end
      end else begin
        if (rx_crs) m_q = 0;
        else if (bit_tick) begin
          if (m_q == (ctrl[4] ? QL : QS) - 1) m_blk = 0;
          else if (m_q < QMAX) m_q++;
        end
      end
      m_rprev = rx_crs;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    check(phase, "tx_cutoff(model)", tx_cutoff, m_cut);
    check(phase, "tx_jab_flag(model)", tx_jab_flag, m_tflag);
    check(phase, "rx_block(model)", rx_block, m_blk);
    check(phase, "rx_wd_flag(model)", rx_wd_flag, m_rflag);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tx_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      tx_byte = 1'b1; @(negedge clk);
    end
    tx_byte = 1'b0;
  endtask

  task automatic rx_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      rx_byte = 1'b1; @(negedge clk);
    end
    rx_byte = 1'b0;
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; @(negedge clk);
      bit_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    rst = 1; ctrl = '0; tx_active = 0; tx_byte = 0; rx_crs = 0; rx_byte = 0; bit_tick = 0;
    cyc(3);
    phase = "R1";
    check("R1", "reset outputs", |{tx_cutoff, rx_block, tx_jab_flag, rx_wd_flag}, 1'b0);
    rst = 0;
    cyc(2);

    // R2: one byte short, then exactly at the limit
    phase = "R2";
    tx_active = 1; cyc(1);
    tx_bytes(TXC - 1); cyc(2);
    check("R2", "below limit", tx_cutoff, 1'b0);
    tx_active = 0; cyc(2);
    tx_active = 1; cyc(1);
    tx_bytes(TXC);
    check("R2", "cut at limit", tx_cutoff, 1'b1);
    check("R2", "flag at limit", tx_jab_flag, 1'b1);

    // R6: long hold, restart while active
    phase = "R6";
    cyc(8);
    check("R6", "held while active", tx_cutoff, 1'b1);
    tx_active = 0; cyc(10);
    tx_active = 1; cyc(2);
    tx_active = 0; cyc(UJ * TPM - 1);
    check("R6", "held one clock early", tx_cutoff, 1'b1);
    cyc(2);
    check("R6", "released after hold", tx_cutoff, 1'b0);
    phase = "R7";
    check("R7", "flag after release", tx_jab_flag, 1'b1);
    tx_active = 1; cyc(1);
    check("R7", "flag cleared on start", tx_jab_flag, 1'b0);
    tx_active = 0; cyc(2);

    // R3: time mode
    phase = "R3";
    ctrl = 5'b00100;
    tx_active = 1; cyc(1 + TC * TPM - 1);
    check("R3", "before time limit", tx_cutoff, 1'b0);
    cyc(1);
    check("R3", "at time limit", tx_cutoff, 1'b1);

    // R5: immediate release
    phase = "R5";
    ctrl = 5'b00110;
    tx_active = 0; cyc(1);
    check("R5", "immediate release", tx_cutoff, 1'b0);
    cyc(2);

    // R4: disabled in both modes
    phase = "R4";
    ctrl = 5'b00001;
    tx_active = 1; cyc(1); tx_bytes(TXC + 10); cyc(2);
    check("R4", "byte mode disabled", tx_cutoff, 1'b0);
    tx_active = 0; cyc(2);
    ctrl = 5'b00101;
    tx_active = 1; cyc(TC * TPM + 8);
    check("R4", "time mode disabled", tx_cutoff, 1'b0);
    tx_active = 0; ctrl = '0; cyc(2);

    // R8: receive trip
    phase = "R8";
    rx_crs = 1; cyc(1); rx_bytes(RXT - 1); cyc(2);
    check("R8", "below rx limit", rx_block, 1'b0);
    rx_crs = 0; cyc(2);
    rx_crs = 1; cyc(1); rx_bytes(RXT);
    check("R8", "blocked at limit", rx_block, 1'b1);
    check("R8", "rx flag at limit", rx_wd_flag, 1'b1);

    // R9: short quiet with a restart
    phase = "R9";
    pulse_ticks(4);
    check("R9", "carrier high keeps block", rx_block, 1'b1);
    rx_crs = 0; pulse_ticks(QS - 1);
    rx_crs = 1; cyc(1); rx_crs = 0;
    pulse_ticks(QS - 1);
    check("R9", "restart after carrier", rx_block, 1'b1);
    pulse_ticks(1);
    check("R9", "short quiet release", rx_block, 1'b0);
    phase = "R10";
    check("R10", "flag after release", rx_wd_flag, 1'b1);

    // R9 long quiet, R10 clear
    ctrl = 5'b10000;
    rx_crs = 1; cyc(1);
    check("R10", "flag cleared on carrier", rx_wd_flag, 1'b0);
    rx_bytes(RXT);
    rx_crs = 0;
    phase = "R9";
    pulse_ticks(QL - 1);
    check("R9", "long quiet not yet", rx_block, 1'b1);
    pulse_ticks(1);
    check("R9", "long quiet release", rx_block, 1'b0);

    // R8 disable
    phase = "R8";
    ctrl = 5'b01000;
    rx_crs = 1; cyc(1); rx_bytes(RXT + 6); cyc(1);
    check("R8", "watchdog disabled", rx_block, 1'b0);
    rx_crs = 0; ctrl = '0; cyc(2);

    // R11: both limits in the same clock
    phase = "R11";
    rx_crs = 1; cyc(1);
    rx_bytes(RXT - TXC);
    tx_active = 1; cyc(1);
    for (int i = 0; i < TXC; i++) begin
      tx_byte = 1; rx_byte = 1; @(negedge clk);
    end
    tx_byte = 0; rx_byte = 0;
    check("R11", "tx cut same cycle", tx_cutoff, 1'b1);
    check("R11", "rx block same cycle", rx_block, 1'b1);
    tx_active = 0; rx_crs = 0; ctrl = 5'b00010;
    pulse_ticks(QS);
    check("R11", "rx released", rx_block, 1'b0);
    check("R11", "tx released", tx_cutoff, 1'b0);

    // R11: random concurrent traffic
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) ctrl = 5'($urandom_range(0, 31)) & 5'b10111;
      if ($urandom_range(0, 99) < 3) tx_active = ~tx_active;
      if ($urandom_range(0, 99) < 4) rx_crs = ~rx_crs;
      tx_byte  = ($urandom_range(0, 99) < 80);
      rx_byte  = ($urandom_range(0, 99) < 80);
      bit_tick = ($urandom_range(0, 99) < 40);
      @(negedge clk);
    end
    tx_active = 0; rx_crs = 0; tx_byte = 0; rx_byte = 0; bit_tick = 0;
    cyc(4);
    finish_run();
  end
endmodule